// File: doc/BRIEF.md
# Chip-Select Kicked Watchdog Timer

This block watches a processor for signs of life on a shared line that is both the serial-bus chip select and the watchdog input. Every high-to-low transition on that line restarts a timeout counter that advances on a millisecond tick enable. If the selected number of ticks passes without a restart, the block raises an expiry request towards the system reset generator. The line counts as dead whether it stays high or stays low, because neither state produces a falling edge.

A two-bit select field, held elsewhere in a status register, chooses one of three intervals or switches the watchdog off. The counter is also restarted by any change of that field, and it is held cleared while the system reset output is active. The count therefore starts fresh on release. A cause flag records whether the last reset came from the watchdog or from a low-supply event.

Top module: `wdk_cs_watchdog`

## Requirements
- R1: The select field `wd_sel` picks the interval in `ms_tick` cycles: 2'b00 = 1400, 2'b01 = 600, 2'b10 = 200. `wd_expire` becomes 1 right after the clock edge that samples the interval-th tick after the last restart, and not earlier.
- R2: A falling edge on `cs_wdi` restarts the count. The line passes through a two-flop synchronizer, so the restart takes effect on the third rising clock edge after the line falls. With ticks on every cycle, `wd_expire` then rises on edge interval+3 counted from the fall. Falling edges that come more often than the interval keep `wd_expire` at 0.
- R3: With `cs_wdi` held steadily high, the watchdog expires after the interval for every enabled setting.
- R4: With `cs_wdi` held steadily low after its last falling edge, the watchdog expires after the interval for every enabled setting.
- R5: `wd_sel` = 2'b11 disables the watchdog: `wd_expire` stays 0 however long the line stays idle.
- R6: While `sys_rst_act` is 1, the count is held cleared and `wd_expire` is 0. After the last edge with `sys_rst_act` = 1, expiry comes on the interval-th edge.
- R7: Any change of `wd_sel` restarts the count on the first edge that sees the new value. The new interval then runs in full from that edge.
- R8: Once raised, `wd_expire` stays 1 until a restart (falling edge, select change or `sys_rst_act`).
- R9: `wd_cause` is set on the edge after `wd_expire` is seen at 1. A `lowv_event` pulse clears it on the next edge and wins when both occur in the same cycle. A system reset alone leaves it unchanged.
- R10: The count advances only on cycles with `ms_tick` = 1. Cycles without a tick neither advance nor restart it.
- R11: While `rst_n` = 0 (synchronous, active low), `wd_expire` and `wd_cause` are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_wdi | input | 1 | Shared chip-select / watchdog line, asynchronous |
| wd_sel | input | 2 | Interval select: 00 long, 01 medium, 10 short, 11 off |
| ms_tick | input | 1 | One-cycle millisecond tick enable |
| sys_rst_act | input | 1 | System reset output currently active |
| lowv_event | input | 1 | Pulse when a low-supply reset is raised |
| wd_expire | output | 1 | Watchdog expiry request to the reset generator (level) |
| wd_cause | output | 1 | 1 when the last reset cause was the watchdog |

## Verification
Each result has a fixed latency. `wd_expire` follows a falling line by interval+3 edges, a select change by interval+1 edges and the release of a system or bench restart by the interval itself. `wd_cause` lags `wd_expire` by one edge. The bench drives inputs on falling clock edges and counts rising edges from a known restart edge. It checks that the output is still low on the edge just before the due one and high on the due edge. In the sparse-tick run, the bench counts the ticks it presents and compares the output one time unit after each rising edge.

// File: rtl/wdk_pkg.sv
// Package: shared encodings for the chip-select kicked watchdog.
// Assumes the select field arrives as two plain bits from a status register.
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/wdk_edge_sync.sv
// Module: brings the asynchronous CS/WDI line into the clock domain and
// emits a one-cycle pulse on each synchronized high-to-low transition.
// Assumes the idle level of the line is high; reset preloads ones so a line
// already high produces no pulse after reset.
module wdk_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall_pulse
);

    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
        end else begin
            shreg <= {shreg[DEPTH-2:0], line_in};
        end
    end

    assign fall_pulse = shreg[DEPTH-1] & ~shreg[DEPTH-2];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse); // R2

endmodule

// File: rtl/wdk_timeout_ctr.sv
// Module: counts millisecond ticks since the last restart and raises a held
// expiry flag once the selected interval is reached.
// Assumes restart_req is already synchronous; the off setting holds it cleared.
module wdk_timeout_ctr
    import wdk_pkg::*;
#(
    parameter int unsigned TMO_LONG  = 1400,
    parameter int unsigned TMO_MID   = 600,
    parameter int unsigned TMO_SHORT = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart_req,
    input  logic [1:0] sel,
    output logic       expire
);

    localparam int unsigned TMO_MAX =
        (TMO_LONG > TMO_MID) ? ((TMO_LONG > TMO_SHORT) ? TMO_LONG : TMO_SHORT)
                             : ((TMO_MID > TMO_SHORT) ? TMO_MID : TMO_SHORT);
    localparam int unsigned CW = $clog2(TMO_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          off;

    // Decode the selected interval and the off setting.
    always_comb begin
        off = 1'b0;
        unique case (wd_sel_e'(sel))
            WD_LONG:  limit = CW'(TMO_LONG);
            WD_MID:   limit = CW'(TMO_MID);
            WD_SHORT: limit = CW'(TMO_SHORT);
            default: begin
                limit = CW'(TMO_SHORT);
                off   = 1'b1;
            end
        endcase
    end

    // Tick counter with held expiry; restarts and the off setting clear both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (restart_req || off) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (tick && !expire) begin
            cnt <= cnt + CW'(1);
            if (cnt == limit - CW'(1)) begin
                expire <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TMO_MAX)); // R1
    AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expire) |-> ($past(cnt) == $past(limit) - CW'(1))); // R1
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> (!expire && cnt == '0)); // R5
    AST_EXPIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart_req && !off) |=> expire); // R8
    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart_req && !off) |=> $stable(cnt)); // R10

endmodule

// File: rtl/wdk_cause_flag.sv
// Module: volatile flag naming the watchdog as the last reset cause.
// Assumes lowv_event is a synchronous pulse; a low-supply event wins a tie.
module wdk_cause_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_fire,
    input  logic lowv_event,
    output logic cause
);

    // Set on watchdog expiry, cleared by a low-supply event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= 1'b0;
        end else if (lowv_event) begin
            cause <= 1'b0;
        end else if (wd_fire) begin
            cause <= 1'b1;
        end
    end

    AST_LOWV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lowv_event |=> !cause); // R9
    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_fire && !lowv_event) |=> cause); // R9

endmodule

// File: rtl/wdk_cs_watchdog.sv
// Module: top of the chip-select kicked watchdog. Combines the line
// synchronizer, the select-change detector, the tick counter and the cause flag.
// Assumes ms_tick is a single-cycle enable and sys_rst_act comes from the
// reset generator that consumes wd_expire.
module wdk_cs_watchdog #(
    parameter int unsigned TMO_LONG  = 1400,
    parameter int unsigned TMO_MID   = 600,
    parameter int unsigned TMO_SHORT = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_wdi,
    input  logic [1:0] wd_sel,
    input  logic       ms_tick,
    input  logic       sys_rst_act,
    input  logic       lowv_event,
    output logic       wd_expire,
    output logic       wd_cause
);

    logic       kick;
    logic [1:0] sel_q;
    logic       sel_chg;
    logic       restart;

    wdk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (cs_wdi),
        .fall_pulse (kick)
    );

    // Remember the select field; reset loads the live value so no restart follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= wd_sel;
        end else begin
            sel_q <= wd_sel;
        end
    end

    assign sel_chg = (wd_sel != sel_q);
    assign restart = kick | sel_chg | sys_rst_act;

    wdk_timeout_ctr #(
        .TMO_LONG  (TMO_LONG),
        .TMO_MID   (TMO_MID),
        .TMO_SHORT (TMO_SHORT)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (ms_tick),
        .restart_req (restart),
        .sel         (wd_sel),
        .expire      (wd_expire)
    );

    wdk_cause_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_fire    (wd_expire),
        .lowv_event (lowv_event),
        .cause      (wd_cause)
    );

    AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |=> !wd_expire); // R6
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wd_expire); // R2
    AST_SELCHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> !wd_expire); // R7

endmodule

// File: tb/wdk_cs_watchdog_bench.sv
module wdk_cs_watchdog_bench;

    localparam int unsigned T_LONG  = 1400;
    localparam int unsigned T_MID   = 600;
    localparam int unsigned T_SHORT = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       ms_tick = 1'b1;
    logic       sys_rst_act = 1'b0;
    logic       lowv_event = 1'b0;
    logic       wd_expire;
    logic       wd_cause;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdk_cs_watchdog u_wdk_cs_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_wdi      (cs_wdi),
        .wd_sel      (wd_sel),
        .ms_tick     (ms_tick),
        .sys_rst_act (sys_rst_act),
        .lowv_event  (lowv_event),
        .wd_expire   (wd_expire),
        .wd_cause    (wd_cause)
    );

    function automatic int unsigned interval(input logic [1:0] s);
        case (s)
            2'b00:   return T_LONG;
            2'b01:   return T_MID;
            default: return T_SHORT;
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Restart edge = the one posedge that sees sys_rst_act high.
    task automatic restart_sys();
        @(negedge clk);
        sys_rst_act = 1'b1;
        @(negedge clk);
        sys_rst_act = 1'b0;
    endtask

    // Low on edge n-1, high on edge n, counted from the current negedge.
    task automatic expect_at(input int unsigned n, input string tag);
        repeat (n - 1) @(negedge clk);
        check(wd_expire, 1'b0, tag);
        @(negedge clk);
        check(wd_expire, 1'b1, tag);
    endtask

    initial begin
        int unsigned tick_seen;
        // R11 reset state
        repeat (3) @(negedge clk);
        check(wd_expire, 1'b0, "R11 expire in reset");
        check(wd_cause, 1'b0, "R11 cause in reset");
        rst_n = 1'b1;

        // R3 steady high, every enabled setting; R1 interval values
        for (int s = 0; s < 3; s++) begin
            wd_sel = 2'(s);
            restart_sys();
            expect_at(interval(2'(s)), "R3 R1 steady high expiry");
        end

        // R4 steady low after one falling edge, every enabled setting
        for (int s = 0; s < 3; s++) begin
            wd_sel = 2'(s);
            cs_wdi = 1'b1;
            restart_sys();
            cs_wdi = 1'b0;
            expect_at(interval(2'(s)) + 3, "R4 R2 steady low expiry");
        end
        cs_wdi = 1'b1;

        // R8 level is held, R9 cause set one edge later
        @(negedge clk);
        check(wd_expire, 1'b1, "R8 expiry held");
        check(wd_cause, 1'b1, "R9 cause set after expiry");
        repeat (20) @(negedge clk);
        check(wd_expire, 1'b1, "R8 expiry still held");

        // R9 tie: lowv wins this edge, expiry sets again next edge
        lowv_event = 1'b1;
        @(negedge clk);
        lowv_event = 1'b0;
        check(wd_cause, 1'b0, "R9 lowv wins tie");
        @(negedge clk);
        check(wd_cause, 1'b1, "R9 cause resets from held expiry");

        // R6 system reset clears expiry, leaves cause alone
        restart_sys();
        check(wd_expire, 1'b0, "R6 expiry cleared by sys reset");
        check(wd_cause, 1'b1, "R9 sys reset keeps cause");
        lowv_event = 1'b1;
        @(negedge clk);
        lowv_event = 1'b0;
        check(wd_cause, 1'b0, "R9 lowv clears cause");

        // R6 long hold of sys reset keeps quiet, then full interval
        wd_sel = 2'b10;
        @(negedge clk);
        sys_rst_act = 1'b1;
        repeat (400) @(negedge clk);
        check(wd_expire, 1'b0, "R6 held quiet during sys reset");
        sys_rst_act = 1'b0;
        expect_at(T_SHORT, "R6 interval after release");

        // R2 periodic kicks keep it quiet
        restart_sys();
        for (int k = 0; k < 6; k++) begin
            cs_wdi = 1'b1;
            repeat (3) @(negedge clk);
            cs_wdi = 1'b0;
            repeat (150) @(negedge clk);
            check(wd_expire, 1'b0, "R2 kicks keep watchdog quiet");
        end
        cs_wdi = 1'b1;

        // R5 disabled setting stays quiet
        @(negedge clk);
        wd_sel = 2'b11;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (k % 250 == 0) check(wd_expire, 1'b0, "R5 disabled stays quiet");
        end

        // R7 change from off to short runs the new interval in full
        wd_sel = 2'b10;
        expect_at(T_SHORT + 1, "R7 select change restart");

        // R7 change mid-count from long to short
        wd_sel = 2'b00;
        restart_sys();
        repeat (500) @(negedge clk);
        check(wd_expire, 1'b0, "R7 long still running");
        wd_sel = 2'b10;
        expect_at(T_SHORT + 1, "R7 mid-count change");

        // R10 sparse ticks: one tick in every three cycles
        ms_tick = 1'b0;
        restart_sys();
        tick_seen = 0;
        for (int k = 0; k < 3 * (T_SHORT + 5); k++) begin
            @(negedge clk);
            ms_tick = (k % 3 == 0);
            @(posedge clk);
            #1;
            if (ms_tick) tick_seen++;
            if (tick_seen + 2 >= T_SHORT || k % 50 == 0)
                check(wd_expire, (tick_seen >= T_SHORT), "R10 counts only ticks");
        end
        ms_tick = 1'b1;

        // R11 reset clears live state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(wd_expire, 1'b0, "R11 expiry cleared by reset");
        check(wd_cause, 1'b0, "R11 cause cleared by reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: bench timed out, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule